// File: doc/BRIEF.md
# Periodic Interrupt Rate and Flag Controller

This block produces the periodic interrupt of a real-time clock and keeps its interrupt flags. A single-cycle enable at 32.768 kHz drives a binary divider chain. A 4-bit rate code picks one power-of-two tap of that chain, and each time the tap wraps the periodic flag is raised. A 3-bit divider-select field names the time base, and two of its values hold the chain at zero. The calendar logic outside the block supplies pulses for "update ended" and "alarm matched".

The flags sit in an 8-bit flag register. Each flag is latched whenever its event occurs, whether or not its interrupt is enabled. The top bit is a summary that is high while any flag is set together with its enable, and the interrupt request output follows that summary. A host read strobe returns the register and clears it. An event that arrives in the same cycle as the read survives into the next read. An 8-bit status register reports the valid-RAM-and-time indication in its top bit. The block has no streaming data path, so every pin is a plain control or status signal.

Top module: `rtc_pirq_top`

## Requirements
- R1: With rate code c in 3..15, the periodic flag (flag register bit 6) is set once every 2^(c-1) time-base ticks (code 3 = 4 ticks, code 15 = 16384 ticks).
- R2: When the divider select is 3'b010 (32 kHz base), codes 1 and 2 give periods of 128 and 256 ticks. Under any other running divider select, they give 1 and 2 ticks.
- R3: Rate code 0 never sets the periodic flag.
- R4: Divider select 3'b110 or 3'b111 holds the chain at zero, and no periodic flag is set while it is held. The first periodic flag after release comes exactly one full period of ticks later.
- R5: Flag register bit 4 (update ended), bit 5 (alarm) and bit 6 (periodic) are set by their events one clock later, whatever their enables are.
- R6: Flag register bit 7 and `irq_o` are 1 exactly when some flag among bits 6:4 is set and its enable is 1. Bits 3:0 always read 0.
- R7: A cycle with `flag_rd_i` high clears all flags at the next clock edge. An event in that same cycle is kept set.
- R8: Status register bit 7 shows `vrt_i` one clock later. Bits 6:0 read 0.
- R9: The divider advances only in cycles where `tick_i` is high, so a sparser tick stretches the period in clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | 32.768 kHz time-base enable, one cycle per tick |
| rate_sel_i | input | 4 | Periodic rate code |
| div_sel_i | input | 3 | Divider/time-base select |
| upd_ie_i | input | 1 | Update-ended interrupt enable |
| alm_ie_i | input | 1 | Alarm interrupt enable |
| per_ie_i | input | 1 | Periodic interrupt enable |
| upd_evt_i | input | 1 | Update-ended event pulse |
| alm_evt_i | input | 1 | Alarm-match event pulse |
| flag_rd_i | input | 1 | Host read strobe of the flag register (clears it) |
| vrt_i | input | 1 | Valid RAM and time indication |
| flag_reg_o | output | 8 | Flag register value |
| stat_reg_o | output | 8 | Status register value |
| irq_o | output | 1 | Active-high interrupt request |

## Verification
Several properties are checked on every cycle: the periodic flag rises only after a tick, with a non-zero rate code and a running divider; events set their flags; a read with no event leaves the register empty; and the unused bits stay zero. Period lengths for each rate code and base, the exact phase after the divider leaves reset, and the stretching under a sparse tick depend on long windows of cycles, so only the bench scenarios can show them.

// File: rtl/rtc_pirq_pkg.sv
package rtc_pirq_pkg;
  parameter int RATE_W  = 4;
  parameter int DSEL_W  = 3;
  parameter int CHAIN_W = 15;
  parameter int NFLAG   = 3;
  parameter int REG_W   = 8;
  localparam logic [DSEL_W-1:0] DSEL_BASE32 = 3'b010;
  localparam int FLAG_LSB = 4;
  localparam int SHIFT_W = $clog2(CHAIN_W);

  typedef struct packed {
    logic per;
    logic alm;
    logic upd;
  } evt_t;
endpackage

// File: rtl/rtc_rate_decode.sv
module rtc_rate_decode
  import rtc_pirq_pkg::*;
(
  input  logic [RATE_W-1:0]  rate_sel,
  input  logic [DSEL_W-1:0]  div_sel,
  output logic               rate_en,
  output logic               chain_hold,
  output logic [CHAIN_W-1:0] tap_mask
);
  logic [SHIFT_W-1:0] shift;
  logic               base32;

  always_comb begin
    base32     = (div_sel == DSEL_BASE32);
    chain_hold = (div_sel[DSEL_W-1:DSEL_W-2] == 2'b11);
    rate_en    = (rate_sel != '0);
    if (base32 && (rate_sel == 4'd1 || rate_sel == 4'd2))
      shift = SHIFT_W'(rate_sel) + SHIFT_W'(6);
    else if (rate_sel == '0)
      shift = '0;
    else
      shift = SHIFT_W'(rate_sel) - SHIFT_W'(1);
    tap_mask = (CHAIN_W'(1) << shift) - CHAIN_W'(1);
  end
endmodule

// File: rtl/rtc_div_chain.sv
module rtc_div_chain
  import rtc_pirq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               hold,
  input  logic               rate_en,
  input  logic [CHAIN_W-1:0] tap_mask,
  output logic               per_pulse
);
  logic [CHAIN_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (hold)   cnt_q <= '0;
    else if (tick)   cnt_q <= cnt_q + CHAIN_W'(1);
  end

  assign per_pulse = tick && !hold && rate_en && ((cnt_q & tap_mask) == tap_mask);
endmodule

// File: rtl/rtc_flag_bank.sv
module rtc_flag_bank
  import rtc_pirq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  evt_t             evt,
  input  evt_t             ena,
  input  logic             rd,
  output logic [REG_W-1:0] reg_val,
  output logic             irq
);
  evt_t flg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  flg_q <= '0;
    else if (rd) flg_q <= evt;
    else         flg_q <= flg_q | evt;
  end

  assign irq     = |(flg_q & ena);
  assign reg_val = {irq, flg_q, {FLAG_LSB{1'b0}}};
endmodule

// File: rtl/rtc_pirq_top.sv
module rtc_pirq_top
  import rtc_pirq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic [RATE_W-1:0] rate_sel_i,
  input  logic [DSEL_W-1:0] div_sel_i,
  input  logic              upd_ie_i,
  input  logic              alm_ie_i,
  input  logic              per_ie_i,
  input  logic              upd_evt_i,
  input  logic              alm_evt_i,
  input  logic              flag_rd_i,
  input  logic              vrt_i,
  output logic [REG_W-1:0]  flag_reg_o,
  output logic [REG_W-1:0]  stat_reg_o,
  output logic              irq_o
);
  logic               rate_en, hold, per_pulse;
  logic [CHAIN_W-1:0] mask;
  logic               vrt_q;
  evt_t               evt, ena;

  rtc_rate_decode u_dec (
    .rate_sel(rate_sel_i), .div_sel(div_sel_i),
    .rate_en(rate_en), .chain_hold(hold), .tap_mask(mask)
  );

  rtc_div_chain u_chain (
    .clk(clk), .rst_n(rst_n), .tick(tick_i), .hold(hold),
    .rate_en(rate_en), .tap_mask(mask), .per_pulse(per_pulse)
  );

  assign evt = '{per: per_pulse, alm: alm_evt_i, upd: upd_evt_i};
  assign ena = '{per: per_ie_i,  alm: alm_ie_i,  upd: upd_ie_i};

  rtc_flag_bank u_flags (
    .clk(clk), .rst_n(rst_n), .evt(evt), .ena(ena), .rd(flag_rd_i),
    .reg_val(flag_reg_o), .irq(irq_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vrt_q <= 1'b0;
    else        vrt_q <= vrt_i;
  end

  assign stat_reg_o = {vrt_q, {(REG_W-1){1'b0}}};
endmodule

// File: rtl/rtc_pirq_chk.sv
module rtc_pirq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick_i,
  input logic [3:0] rate_sel_i,
  input logic [2:0] div_sel_i,
  input logic       upd_evt_i,
  input logic       alm_evt_i,
  input logic       flag_rd_i,
  input logic [7:0] flag_reg_o,
  input logic [7:0] stat_reg_o,
  input logic       irq_o
);
  // R3
  no_rate0_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_reg_o[6]) |-> $past(rate_sel_i) != 4'd0);
  // R4
  hold_blocks_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_reg_o[6]) |-> $past(div_sel_i[2:1]) != 2'b11);
  // R9
  tick_gates_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_reg_o[6]) |-> $past(tick_i));
  // R5
  upd_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_evt_i |=> flag_reg_o[4]);
  // R5
  alm_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alm_evt_i |=> flag_reg_o[5]);
  // R7
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_rd_i && !upd_evt_i && !alm_evt_i) |=> flag_reg_o[5:4] == 2'b00);
  // R6
  irq_summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> flag_reg_o[7] && (flag_reg_o[6:4] != 3'b000));
  // R6
  low_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_reg_o[3:0] == 4'h0);
  // R8
  stat_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_reg_o[6:0] == 7'h00);
endmodule

bind rtc_pirq_top rtc_pirq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .rate_sel_i(rate_sel_i),
  .div_sel_i(div_sel_i), .upd_evt_i(upd_evt_i), .alm_evt_i(alm_evt_i),
  .flag_rd_i(flag_rd_i), .flag_reg_o(flag_reg_o), .stat_reg_o(stat_reg_o),
  .irq_o(irq_o)
);

// File: tb/sim_rtc_pirq_top.sv
`timescale 1ns/1ps
module sim_rtc_pirq_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1, tick_sparse = 1'b0;
  logic [3:0] rate = 4'd0;
  logic [2:0] dsel = 3'b111;
  logic upd_ie = 0, alm_ie = 0, per_ie = 0, upd_ev = 0, alm_ev = 0, rd = 0, vrt = 0;
  logic [7:0] flags, stat;
  logic irq;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  always @(negedge clk) if (tick_sparse) tick <= ~tick; else tick <= 1'b1;

  rtc_pirq_top u0 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .rate_sel_i(rate), .div_sel_i(dsel),
    .upd_ie_i(upd_ie), .alm_ie_i(alm_ie), .per_ie_i(per_ie),
    .upd_evt_i(upd_ev), .alm_evt_i(alm_ev), .flag_rd_i(rd), .vrt_i(vrt),
    .flag_reg_o(flags), .stat_reg_o(stat), .irq_o(irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(); @(posedge clk); @(negedge clk); endtask

  // Clears flags while the chain is held, releases with the given setup,
  // and counts clock edges until the periodic flag appears.
  task automatic measure(input logic [3:0] code, input logic [2:0] dv, input int lim, output int n);
    @(negedge clk);
    dsel = 3'b111; rd = 1; step(); rd = 0;
    rate = code; dsel = dv; n = 0;
    while (n < lim && !flags[6]) begin step(); n++; end
  endtask

  task automatic t_reset();
    check(flags == 8'h00, "R6 reset flags", flags, 0);
    check(stat == 8'h00, "R8 reset status", stat, 0);
    check(irq == 1'b0, "R6 reset irq", irq, 0);
  endtask

  task automatic t_rates();
    int n;
    measure(4'd3, 3'b000, 100, n);    check(n == 4, "R1 code3", n, 4);
    measure(4'd6, 3'b010, 100, n);    check(n == 32, "R1 code6", n, 32);
    measure(4'd15, 3'b010, 20000, n); check(n == 16384, "R1 code15", n, 16384);
    measure(4'd1, 3'b010, 1000, n);   check(n == 128, "R2 code1 base32", n, 128);
    measure(4'd2, 3'b010, 1000, n);   check(n == 256, "R2 code2 base32", n, 256);
    measure(4'd1, 3'b000, 100, n);    check(n == 1, "R2 code1 other", n, 1);
    measure(4'd2, 3'b001, 100, n);    check(n == 2, "R2 code2 other", n, 2);
  endtask

  task automatic t_repeat();
    int n;
    measure(4'd4, 3'b010, 100, n); check(n == 8, "R1 code4 first", n, 8);
    rd = 1; step(); rd = 0; n = 1;
    check(flags[6] == 1'b0, "R7 periodic cleared", flags[6], 0);
    while (n < 100 && !flags[6]) begin step(); n++; end
    check(n == 8, "R1 code4 repeat", n, 8);
  endtask

  task automatic t_off();
    int n;
    measure(4'd0, 3'b010, 3000, n); check(n == 3000, "R3 code0 silent", n, 3000);
    measure(4'd3, 3'b110, 3000, n); check(n == 3000, "R4 held 110", n, 3000);
    measure(4'd3, 3'b111, 3000, n); check(n == 3000, "R4 held 111", n, 3000);
  endtask

  task automatic t_sparse();
    int n;
    tick_sparse = 1;
    measure(4'd3, 3'b010, 100, n);
    check(n >= 7 && n <= 8, "R9 sparse tick", n, 8);
    tick_sparse = 0;
  endtask

  task automatic t_flags();
    @(negedge clk); dsel = 3'b111; rd = 1; step(); rd = 0;
    upd_ev = 1; step(); upd_ev = 0;
    check(flags == 8'h10, "R5 upd flag no enable", flags, 8'h10);
    check(irq == 0, "R6 irq off without enable", irq, 0);
    upd_ie = 1; step();
    check(flags == 8'h90 && irq, "R6 summary with enable", flags, 8'h90);
    alm_ev = 1; step(); alm_ev = 0;
    check(flags == 8'hB0, "R5 alarm flag", flags, 8'hB0);
    rd = 1; step(); rd = 0;
    check(flags == 8'h00 && !irq, "R7 read clears", flags, 0);
    alm_ie = 1; rd = 1; alm_ev = 1; step(); rd = 0; alm_ev = 0;
    check(flags == 8'hA0 && irq, "R7 same-cycle event kept", flags, 8'hA0);
    rd = 1; step(); rd = 0;
    check(flags == 8'h00, "R7 second read clears", flags, 0);
    upd_ie = 0; alm_ie = 0;
  endtask

  task automatic t_per_irq();
    int n;
    per_ie = 0;
    measure(4'd3, 3'b010, 100, n);
    check(flags == 8'h40 && !irq, "R5 periodic flag no enable", flags, 8'h40);
    per_ie = 1; step();
    check(flags[7] && irq, "R6 periodic summary", flags, 8'hC0);
    per_ie = 0; dsel = 3'b111;
  endtask

  task automatic t_vrt();
    vrt = 1; step();
    check(stat == 8'h80, "R8 vrt set", stat, 8'h80);
    vrt = 0; step();
    check(stat == 8'h00, "R8 vrt clear", stat, 0);
  endtask

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    step();
    t_rates();
    t_repeat();
    t_off();
    t_sparse();
    t_flags();
    t_per_irq();
    t_vrt();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule